// File: doc/BRIEF.md
# Breakpoint Line-Type Sync Generator

This block is the timing core of a video output path. A pixel counter and a line counter run from the pixel clock once a start strobe arrives. For every line, the block reports a 4-bit line-type code. The code is looked up in a programmable table of sixteen breakpoints, where each entry pairs a starting line number with a line type. Downstream blanking and sync-level logic uses this code to decide what each line carries.

The block also produces a horizontal and a vertical sync pulse. Each pulse has a programmable position and length. The vertical pulse has a separate position and length for each of the two fields of an interlaced frame. A field flag tracks which half of an interlaced frame is in progress. Each pulse has its own polarity select. A pulse whose position falls outside the line or the frame is never produced. For a progressive frame, the second-field pulse is switched off by giving it a zero length and an all-ones line number.

All outputs are registered, and all of them describe the same pixel at the same time. In any cycle, the line type, both sync outputs and the field flag belong to the pixel and line counts shown in that cycle.

Top module: `linetype_sync_gen`

## Requirements
- R1: Before the first start strobe, after reset, the outputs are idle: pixel count 0, line count 0, line type 0, field flag 0, and both sync outputs at their inactive level. In the cycle after a start strobe is sampled, the pixel count is 0 and the line count is 1. This holds even while the counters are already running.
- R2: While running, the pixel count steps by one each clock from 0 to total_pixels-1, then returns to 0.
- R3: The line count advances by one when the pixel count returns to 0. After line frame_lines, it returns to 1.
- R4: Breakpoint i occupies bits [i*11 +: 11] of bp_lines (line number) and bits [i*4 +: 4] of bp_types (line type). The line type shown is the type of the highest-indexed breakpoint whose line number is at or below the current line. Codes are 4'h0 to 4'hF, with 4'h0 meaning active video. Unused entries set to line 2047 are never selected on earlier lines.
- R5: Lines below every breakpoint's line number take the type of breakpoint 0.
- R6: The horizontal sync is active on pixel indices hs_delay through hs_delay+hs_length-1. A window that runs past the last pixel ends at the end of the line and does not continue into the next line.
- R7: When hs_delay is greater than total_pixels, the horizontal sync never becomes active.
- R8: When the field flag is 0, the vertical sync is active on whole lines vs1_delay through vs1_delay+vs1_length-1.
- R9: With interlace set, the field flag is 1 on lines above field1_lines and 0 otherwise. While it is 1, the vertical sync uses vs2_delay and vs2_length. With interlace clear, the flag stays 0.
- R10: The vertical sync never becomes active when the delay in use is greater than frame_lines. A progressive setup (vs2_length 0, vs2_delay all ones) gives exactly one vertical pulse per frame.
- R11: A polarity bit of 1 makes its sync output active high. A polarity bit of 0 makes it active low.
- R12: Line type, sync outputs and field flag are registered. They change in the same cycle as the pixel and line counts they describe, so a new line's type first appears together with pixel 0 of that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe; restarts counting at line 1, pixel 0 |
| total_pixels | input | 13 | Pixels per line |
| frame_lines | input | 11 | Lines per frame |
| field1_lines | input | 11 | Last line of the first field (interlaced) |
| interlace | input | 1 | 1 = interlaced field tracking |
| bp_lines | input | 176 | Sixteen 11-bit breakpoint line numbers |
| bp_types | input | 64 | Sixteen 4-bit breakpoint line types |
| hs_delay | input | 13 | First pixel of horizontal sync |
| hs_length | input | 10 | Horizontal sync length in pixels |
| vs1_delay | input | 11 | First line of vertical sync, field 1 |
| vs1_length | input | 10 | Vertical sync length in lines, field 1 |
| vs2_delay | input | 11 | First line of vertical sync, field 2 |
| vs2_length | input | 10 | Vertical sync length in lines, field 2 |
| hs_pol | input | 1 | Horizontal sync polarity, 1 = active high |
| vs_pol | input | 1 | Vertical sync polarity, 1 = active high |
| line_type | output | 4 | Line type of the current line |
| pix_cnt | output | 13 | Current pixel index |
| line_cnt | output | 11 | Current line number (0 while idle) |
| hs_out | output | 1 | Horizontal sync |
| vs_out | output | 1 | Vertical sync |
| field | output | 1 | Field flag, 1 = second field |

## Verification
The bench builds the block with its default widths: 13-bit pixel count, 11-bit line count, sixteen breakpoints and 4-bit types. It programs a short raster of 20 pixels by 12 lines, so full frames, frame wraps and both fields of an interlaced frame complete in a few hundred cycles. Only three breakpoints are placed inside that raster. The remaining thirteen sit at line 2047, which tests that unused entries stay out of the selection. Sync windows are placed against the last pixel and beyond the raster to reach truncation and suppression.

// File: rtl/lts_pkg.sv
// Package: shared widths and line-type code points for the breakpoint
// line-type sync generator. Assumes 4-bit line-type codes.
package lts_pkg;
    localparam int LTS_TYPE_W = 4;
    typedef logic [LTS_TYPE_W-1:0] line_type_t;

    // Named code points used by neighbours; any 4-bit value is legal.
    localparam line_type_t LT_ACTIVE     = 4'h0;
    localparam line_type_t LT_FIRST_SYNC = 4'h1;
    localparam line_type_t LT_LAST_SYNC  = 4'hF;
endpackage

// File: rtl/lts_counters.sv
// Module: lts_counters
// Pixel and line counters with the field flag. Exposes both the next-state
// values (so the top can register outputs aligned to the counts) and the
// registered counts. Assumes total_pixels >= 1 and frame_lines >= 1.
module lts_counters #(
    parameter int PIX_W  = 13,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PIX_W-1:0]  total_pixels,
    input  logic [LINE_W-1:0] frame_lines,
    input  logic [LINE_W-1:0] field1_lines,
    input  logic              interlace,
    output logic              run_n,
    output logic [PIX_W-1:0]  pix_n,
    output logic [LINE_W-1:0] line_n,
    output logic              field_n,
    output logic [PIX_W-1:0]  pix_q,
    output logic [LINE_W-1:0] line_q,
    output logic              field_q
);
    localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

    logic             run_q;
    logic [PIX_W:0]   pix_inc;

    assign pix_inc = {1'b0, pix_q} + 1'b1;

    // Next-state: restart on strobe, otherwise step pixel and wrap line/frame.
    always_comb begin
        run_n  = run_q;
        pix_n  = pix_q;
        line_n = line_q;
        if (start) begin
            run_n  = 1'b1;
            pix_n  = '0;
            line_n = LINE_ONE;
        end else if (run_q) begin
            if (pix_inc >= {1'b0, total_pixels}) begin
                pix_n = '0;
                if (line_q >= frame_lines) begin
                    line_n = LINE_ONE;
                end else begin
                    line_n = line_q + 1'b1;
                end
            end else begin
                pix_n = pix_inc[PIX_W-1:0];
            end
        end
        field_n = run_n && interlace && (line_n > field1_lines);
    end

    // State registers, cleared to idle by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            pix_q   <= '0;
            line_q  <= '0;
            field_q <= 1'b0;
        end else begin
            run_q   <= run_n;
            pix_q   <= pix_n;
            line_q  <= line_n;
            field_q <= field_n;
        end
    end
endmodule

// File: rtl/lts_bp_scan.sv
// Module: lts_bp_scan
// Combinational breakpoint lookup: returns the type of the highest-indexed
// breakpoint whose line number is at or below the given line, or the type
// of entry 0 when none qualifies. Assumes the table is sorted ascending.
module lts_bp_scan #(
    parameter int NUM_BP = 16,
    parameter int LINE_W = 11,
    parameter int TYPE_W = 4
) (
    input  logic [LINE_W-1:0]        line,
    input  logic [NUM_BP*LINE_W-1:0] bp_lines,
    input  logic [NUM_BP*TYPE_W-1:0] bp_types,
    output logic [TYPE_W-1:0]        sel_type
);
    logic [NUM_BP-1:0] reached;

    // One comparator per table entry.
    for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
        assign reached[g] = (bp_lines[g*LINE_W +: LINE_W] <= line);
    end

    // Priority select: later entries override earlier ones.
    always_comb begin
        sel_type = bp_types[TYPE_W-1:0];
        for (int i = 0; i < NUM_BP; i++) begin
            if (reached[i]) begin
                sel_type = bp_types[i*TYPE_W +: TYPE_W];
            end
        end
    end
endmodule

// File: rtl/lts_pulse_win.sv
// Module: lts_pulse_win
// Window comparator for a sync pulse: active for delay <= pos < delay+len,
// with the sum formed one bit wider so it never wraps. Suppressed entirely
// when delay exceeds the given limit or when enable is low.
module lts_pulse_win #(
    parameter int POS_W = 13,
    parameter int LEN_W = 10
) (
    input  logic             enable,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] delay,
    input  logic [LEN_W-1:0] len,
    input  logic [POS_W-1:0] limit,
    output logic             active
);
    localparam int SUM_W = ((POS_W > LEN_W) ? POS_W : LEN_W) + 1;

    logic [SUM_W-1:0] win_end;

    // Exclusive end of the window.
    assign win_end = SUM_W'(delay) + SUM_W'(len);

    // Window membership with out-of-range suppression.
    assign active = enable && (delay <= limit) && (pos >= delay)
                    && (SUM_W'(pos) < win_end);
endmodule

// File: rtl/linetype_sync_gen.sv
// Module: linetype_sync_gen (top)
// Display timing core: counters, breakpoint line-type lookup, and
// horizontal/vertical sync windows with per-field vertical settings and
// polarity. All outputs are registered from next-state counts so that they
// line up with pix_cnt/line_cnt in the same cycle. Synchronous reset.
module linetype_sync_gen #(
    parameter int PIX_W  = 13,
    parameter int LINE_W = 11,
    parameter int NUM_BP = 16,
    parameter int TYPE_W = lts_pkg::LTS_TYPE_W,
    parameter int HLEN_W = 10,
    parameter int VLEN_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [PIX_W-1:0]         total_pixels,
    input  logic [LINE_W-1:0]        frame_lines,
    input  logic [LINE_W-1:0]        field1_lines,
    input  logic                     interlace,
    input  logic [NUM_BP*LINE_W-1:0] bp_lines,
    input  logic [NUM_BP*TYPE_W-1:0] bp_types,
    input  logic [PIX_W-1:0]         hs_delay,
    input  logic [HLEN_W-1:0]        hs_length,
    input  logic [LINE_W-1:0]        vs1_delay,
    input  logic [VLEN_W-1:0]        vs1_length,
    input  logic [LINE_W-1:0]        vs2_delay,
    input  logic [VLEN_W-1:0]        vs2_length,
    input  logic                     hs_pol,
    input  logic                     vs_pol,
    output logic [TYPE_W-1:0]        line_type,
    output logic [PIX_W-1:0]         pix_cnt,
    output logic [LINE_W-1:0]        line_cnt,
    output logic                     hs_out,
    output logic                     vs_out,
    output logic                     field
);
    logic              run_n;
    logic [PIX_W-1:0]  pix_n;
    logic [LINE_W-1:0] line_n;
    logic              field_n;
    logic [TYPE_W-1:0] type_n;
    logic              hs_act_n;
    logic              vs_act_n;
    logic [LINE_W-1:0] vs_dly_sel;
    logic [VLEN_W-1:0] vs_len_sel;
    logic [TYPE_W-1:0] type_q;
    logic              hs_q;
    logic              vs_q;

    lts_counters #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .total_pixels (total_pixels),
        .frame_lines  (frame_lines),
        .field1_lines (field1_lines),
        .interlace    (interlace),
        .run_n        (run_n),
        .pix_n        (pix_n),
        .line_n       (line_n),
        .field_n      (field_n),
        .pix_q        (pix_cnt),
        .line_q       (line_cnt),
        .field_q      (field)
    );

    lts_bp_scan #(.NUM_BP(NUM_BP), .LINE_W(LINE_W), .TYPE_W(TYPE_W)) u_scan (
        .line     (line_n),
        .bp_lines (bp_lines),
        .bp_types (bp_types),
        .sel_type (type_n)
    );

    lts_pulse_win #(.POS_W(PIX_W), .LEN_W(HLEN_W)) u_hwin (
        .enable (run_n),
        .pos    (pix_n),
        .delay  (hs_delay),
        .len    (hs_length),
        .limit  (total_pixels),
        .active (hs_act_n)
    );

    // Per-field choice of vertical window settings.
    always_comb begin
        vs_dly_sel = field_n ? vs2_delay  : vs1_delay;
        vs_len_sel = field_n ? vs2_length : vs1_length;
    end

    lts_pulse_win #(.POS_W(LINE_W), .LEN_W(VLEN_W)) u_vwin (
        .enable (run_n),
        .pos    (line_n),
        .delay  (vs_dly_sel),
        .len    (vs_len_sel),
        .limit  (frame_lines),
        .active (vs_act_n)
    );

    // Output registers: type held at 0 while idle, syncs driven at the polarity level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= '0;
            hs_q   <= !hs_pol;
            vs_q   <= !vs_pol;
        end else begin
            type_q <= run_n ? type_n : '0;
            hs_q   <= hs_act_n ? hs_pol : !hs_pol;
            vs_q   <= vs_act_n ? vs_pol : !vs_pol;
        end
    end

    assign line_type = type_q;
    assign hs_out    = hs_q;
    assign vs_out    = vs_q;
endmodule

// File: rtl/lts_sync_checker.sv
// Module: lts_sync_checker
// Protocol checks for linetype_sync_gen, attached by bind below.
module lts_sync_checker #(
    parameter int PIX_W  = 13,
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [PIX_W-1:0]  total_pixels,
    input logic [LINE_W-1:0] frame_lines,
    input logic              interlace,
    input logic [PIX_W-1:0]  hs_delay,
    input logic [LINE_W-1:0] vs1_delay,
    input logic [LINE_W-1:0] vs2_delay,
    input logic              hs_pol,
    input logic              vs_pol,
    input logic [PIX_W-1:0]  pix_cnt,
    input logic [LINE_W-1:0] line_cnt,
    input logic              hs_out,
    input logic              vs_out,
    input logic              field
);
    logic [PIX_W:0] pix_step;
    assign pix_step = {1'b0, pix_cnt} + 1'b1;

    a_r1_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (pix_cnt == '0 && line_cnt == LINE_W'(1)));

    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cnt == '0 && !start) |=> (line_cnt == '0 && pix_cnt == '0));

    a_r2_pixel_step: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cnt != '0 && !start && pix_step < {1'b0, total_pixels})
        |=> pix_cnt == PIX_W'($past(pix_cnt) + 1'b1));

    a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cnt != '0 && !start && pix_step >= {1'b0, total_pixels}
         && line_cnt >= frame_lines)
        |=> (line_cnt == LINE_W'(1) && pix_cnt == '0));

    a_r7_hs_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_delay > total_pixels) |=> (hs_out == !$past(hs_pol)));

    a_r10_vs_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        (vs1_delay > frame_lines && vs2_delay > frame_lines)
        |=> (vs_out == !$past(vs_pol)));

    a_r9_progressive_field: assert property (@(posedge clk) disable iff (!rst_n)
        !interlace |=> !field);
endmodule

bind linetype_sync_gen lts_sync_checker #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .total_pixels (total_pixels),
    .frame_lines  (frame_lines),
    .interlace    (interlace),
    .hs_delay     (hs_delay),
    .vs1_delay    (vs1_delay),
    .vs2_delay    (vs2_delay),
    .hs_pol       (hs_pol),
    .vs_pol       (vs_pol),
    .pix_cnt      (pix_cnt),
    .line_cnt     (line_cnt),
    .hs_out       (hs_out),
    .vs_out       (vs_out),
    .field        (field)
);

// File: tb/sim_linetype_sync_gen.sv
// Directed bench for linetype_sync_gen: a cycle model built from the
// requirements is compared every cycle, and each scenario task adds its
// own targeted checks.
module sim_linetype_sync_gen;
    localparam int PIX_W  = 13;
    localparam int LINE_W = 11;
    localparam int NUM_BP = 16;
    localparam int TYPE_W = 4;
    localparam int HLEN_W = 10;
    localparam int VLEN_W = 10;
    localparam int TOT    = 20;
    localparam int FRM    = 12;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                     rst_n;
    logic                     start;
    logic [PIX_W-1:0]         total_pixels;
    logic [LINE_W-1:0]        frame_lines;
    logic [LINE_W-1:0]        field1_lines;
    logic                     interlace;
    logic [NUM_BP*LINE_W-1:0] bp_lines;
    logic [NUM_BP*TYPE_W-1:0] bp_types;
    logic [PIX_W-1:0]         hs_delay;
    logic [HLEN_W-1:0]        hs_length;
    logic [LINE_W-1:0]        vs1_delay;
    logic [VLEN_W-1:0]        vs1_length;
    logic [LINE_W-1:0]        vs2_delay;
    logic [VLEN_W-1:0]        vs2_length;
    logic                     hs_pol;
    logic                     vs_pol;
    logic [TYPE_W-1:0]        line_type;
    logic [PIX_W-1:0]         pix_cnt;
    logic [LINE_W-1:0]        line_cnt;
    logic                     hs_out;
    logic                     vs_out;
    logic                     field;

    int bp_l [NUM_BP];
    int bp_t [NUM_BP];

    always_comb begin
        for (int i = 0; i < NUM_BP; i++) begin
            bp_lines[i*LINE_W +: LINE_W] = LINE_W'(bp_l[i]);
            bp_types[i*TYPE_W +: TYPE_W] = TYPE_W'(bp_t[i]);
        end
    end

    linetype_sync_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .total_pixels(total_pixels), .frame_lines(frame_lines),
        .field1_lines(field1_lines), .interlace(interlace),
        .bp_lines(bp_lines), .bp_types(bp_types),
        .hs_delay(hs_delay), .hs_length(hs_length),
        .vs1_delay(vs1_delay), .vs1_length(vs1_length),
        .vs2_delay(vs2_delay), .vs2_length(vs2_length),
        .hs_pol(hs_pol), .vs_pol(vs_pol),
        .line_type(line_type), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
        .hs_out(hs_out), .vs_out(vs_out), .field(field)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model of the counters, updated on each rising edge.
    bit m_run;
    int m_pix;
    int m_line;
    bit m_field;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_pix = 0; m_line = 0;
        end else if (start) begin
            m_run = 1; m_pix = 0; m_line = 1;
        end else if (m_run) begin
            if (m_pix + 1 >= int'(total_pixels)) begin
                m_pix = 0;
                if (m_line >= int'(frame_lines)) m_line = 1;
                else m_line = m_line + 1;
            end else begin
                m_pix = m_pix + 1;
            end
        end
        m_field = m_run && interlace && (m_line > int'(field1_lines));
    end

    function automatic int exp_type();
        int t;
        if (!m_run) return 0;
        t = bp_t[0];
        for (int i = 0; i < NUM_BP; i++) if (bp_l[i] <= m_line) t = bp_t[i];
        return t;
    endfunction

    function automatic int exp_hs();
        bit act;
        int d = int'(hs_delay);
        act = m_run && (d <= int'(total_pixels)) && (m_pix >= d)
              && (m_pix < d + int'(hs_length));
        return act ? int'(hs_pol) : int'(!hs_pol);
    endfunction

    function automatic int exp_vs();
        bit act;
        int d = m_field ? int'(vs2_delay) : int'(vs1_delay);
        int n = m_field ? int'(vs2_length) : int'(vs1_length);
        act = m_run && (d <= int'(frame_lines)) && (m_line >= d) && (m_line < d + n);
        return act ? int'(vs_pol) : int'(!vs_pol);
    endfunction

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check_eq("R2 pixel count", int'(pix_cnt), m_pix);
            check_eq("R3 line count", int'(line_cnt), m_line);
            check_eq("R4 line type", int'(line_type), exp_type());
            check_eq("R6 hs level", int'(hs_out), exp_hs());
            check_eq("R8 vs level", int'(vs_out), exp_vs());
            check_eq("R9 field flag", int'(field), int'(m_field));
        end
    end

    // Pulse start at the current negedge; returns one negedge later.
    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_pos(input int ln, input int px);
        for (int k = 0; k < 1000; k++) begin
            if (int'(line_cnt) == ln && int'(pix_cnt) == px) return;
            @(negedge clk);
        end
        check_eq("R3 position reached", int'(line_cnt), ln);
    endtask

    task automatic measure(input int ncyc, output int hs_n, output int vs_n, output int fl_n);
        hs_n = 0; vs_n = 0; fl_n = 0;
        for (int k = 0; k < ncyc; k++) begin
            if (hs_out == hs_pol) hs_n++;
            if (vs_out == vs_pol) vs_n++;
            if (field) fl_n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R1 idle pixel", int'(pix_cnt), 0);
        check_eq("R1 idle line", int'(line_cnt), 0);
        check_eq("R1 idle type", int'(line_type), 0);
        check_eq("R1 idle hs", int'(hs_out), int'(!hs_pol));
        check_eq("R1 idle vs", int'(vs_out), int'(!vs_pol));
        check_eq("R1 idle field", int'(field), 0);
        cmp_en = 1'b1;
    endtask

    task automatic t_progressive();
        int h, v, f;
        @(negedge clk);
        do_start();
        check_eq("R1 start pixel", int'(pix_cnt), 0);
        check_eq("R1 start line", int'(line_cnt), 1);
        check_eq("R5 below first breakpoint", int'(line_type), 5);
        measure(TOT*FRM, h, v, f);
        check_eq("R6 hs cycles per frame", h, FRM*5);
        check_eq("R10 single vs pulse per frame", v, 2*TOT);
        check_eq("R9 progressive field", f, 0);
        check_eq("R3 frame wrap line", int'(line_cnt), 1);
        wait_pos(5, TOT-1);
        check_eq("R12 type before boundary", int'(line_type), 5);
        @(negedge clk);
        check_eq("R12 new line pixel", int'(pix_cnt), 0);
        check_eq("R12 type at first pixel", int'(line_type), 0);
        wait_pos(11, 3);
        check_eq("R4 unused entries ignored", int'(line_type), 11);
    endtask

    task automatic t_hs_edge();
        int h, v, f;
        @(negedge clk);
        cmp_en = 1'b0;
        hs_delay = 13'd18; hs_length = 10'd10;
        do_start();
        cmp_en = 1'b1;
        measure(TOT, h, v, f);
        check_eq("R6 window truncated at line end", h, 2);
        cmp_en = 1'b0;
        hs_delay = 13'd21;
        do_start();
        cmp_en = 1'b1;
        measure(TOT*FRM, h, v, f);
        check_eq("R7 hs suppressed", h, 0);
        cmp_en = 1'b0;
        hs_delay = 13'd2; hs_length = 10'd5;
        do_start();
        cmp_en = 1'b1;
    endtask

    task automatic t_interlaced();
        int h, v, f;
        @(negedge clk);
        cmp_en = 1'b0;
        interlace = 1'b1; field1_lines = 11'd6;
        vs1_delay = 11'd2; vs1_length = 10'd2;
        vs2_delay = 11'd8; vs2_length = 10'd3;
        do_start();
        cmp_en = 1'b1;
        measure(TOT*FRM, h, v, f);
        check_eq("R9 second field cycles", f, 6*TOT);
        check_eq("R9 vs cycles both fields", v, 5*TOT);
        wait_pos(7, 0);
        check_eq("R9 field rises on line 7", int'(field), 1);
        wait_pos(9, 4);
        check_eq("R9 field-2 vs active", int'(vs_out), int'(vs_pol));
        wait_pos(1, 0);
        check_eq("R9 field clears at frame start", int'(field), 0);
    endtask

    task automatic t_vs_suppress();
        int h, v, f;
        @(negedge clk);
        cmp_en = 1'b0;
        interlace = 1'b0;
        vs1_delay = 11'd13; vs1_length = 10'd2;
        vs2_delay = 11'h7FF; vs2_length = 10'd0;
        do_start();
        cmp_en = 1'b1;
        measure(TOT*FRM, h, v, f);
        check_eq("R10 vs suppressed", v, 0);
    endtask

    task automatic t_polarity();
        int h, v, f;
        @(negedge clk);
        cmp_en = 1'b0;
        hs_pol = 1'b0; vs_pol = 1'b0;
        vs1_delay = 11'd3; vs1_length = 10'd2;
        do_start();
        cmp_en = 1'b1;
        wait_pos(3, 2);
        check_eq("R11 hs active low", int'(hs_out), 0);
        check_eq("R11 vs active low", int'(vs_out), 0);
        wait_pos(5, 10);
        check_eq("R11 hs idle high", int'(hs_out), 1);
        check_eq("R11 vs idle high", int'(vs_out), 1);
        wait_pos(1, 0);
        measure(TOT*FRM, h, v, f);
        check_eq("R11 low hs cycles", h, FRM*5);
    endtask

    task automatic t_restart();
        wait_pos(7, 9);
        do_start();
        check_eq("R1 restart pixel", int'(pix_cnt), 0);
        check_eq("R1 restart line", int'(line_cnt), 1);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0;
        total_pixels = 13'(TOT); frame_lines = 11'(FRM);
        field1_lines = 11'd6; interlace = 1'b0;
        for (int i = 0; i < NUM_BP; i++) begin
            bp_l[i] = 2047; bp_t[i] = 15;
        end
        bp_l[0] = 3;  bp_t[0] = 5;
        bp_l[1] = 6;  bp_t[1] = 0;
        bp_l[2] = 10; bp_t[2] = 11;
        hs_delay = 13'd2; hs_length = 10'd5;
        vs1_delay = 11'd3; vs1_length = 10'd2;
        vs2_delay = 11'h7FF; vs2_length = 10'd0;
        hs_pol = 1'b1; vs_pol = 1'b1;
        t_reset();
        t_progressive();
        t_hs_edge();
        t_interlaced();
        t_vs_suppress();
        t_polarity();
        t_restart();
        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule